// File: doc/BRIEF.md
# UART Modem Handshake Control and Status

This block is the modem-handshake slice of a 16550-class serial port. A control register drives four active-low handshake outputs: data-terminal-ready, request-to-send and two user outputs. A status register reports the live level of the four incoming modem lines: clear-to-send, data-set-ready, ring indicator and carrier detect. Each incoming line has a sticky change flag. Reading the status register clears all of these flags.

The incoming lines pass through a two-stage synchronizer before change detection. An interrupt request is raised when the modem-status interrupt is enabled and a counted change flag is set. When auto-CTS is enabled, a change on clear-to-send still sets its flag but does not raise the interrupt. In that mode clear-to-send instead produces a transmit-permit signal for the transmitter.

A loopback mode takes the four status lines from the control bits inside the block and parks all four outputs at their inactive (high) level. The CPU uses a small register port. That port answers only when two select inputs are high and a third select input is low.

Top module: `uart_modem_ctl`

## Requirements
- R1: Register accesses take effect only when `sel_a`=1, `sel_b`=1 and `sel_c_n`=0. Under any other combination a write changes nothing, a read returns 0x00 on `rd_data`, and a status read does not clear the change flags.
- R2: The control register sits at address 0 and reads back what was written in bits [4:0], with 0 in bits [7:5]. Bit 0 is DTR, bit 1 is RTS, bit 2 is OUT1, bit 3 is OUT2 and bit 4 is LOOP. Outside loop mode each output pin (`dtr_n`, `rts_n`, `out1_n`, `out2_n`) is the inverse of its bit.
- R3: While LOOP=1, all four output pins are high. The status lines are then taken internally: CTS from RTS, DSR from DTR, RI from OUT1 and DCD from OUT2.
- R4: The status register is at address 1. Bit 4 is CTS, bit 5 is DSR, bit 6 is RI and bit 7 is DCD, each 1 when its active-low pin is low. A pin change driven before clock edge k is visible after edge k+2.
- R5: Status bits 0, 1 and 3 set on any level change of CTS, DSR and DCD respectively. Bit 2 sets only when RI goes from active to inactive. Set flags stay set until cleared.
- R6: A status read clears bits [3:0] at the read's clock edge. A change detected on that same edge is kept.
- R7: The mode register is at address 2, with bit 0 as the interrupt enable and bit 1 as the auto-CTS enable. `irq` is 1 exactly when the interrupt enable is 1 and any of flag bits 1 to 3 is set, or flag bit 0 is set while auto-CTS is 0.
- R8: `tx_allow` equals the CTS status bit while auto-CTS is 1, and is 1 otherwise.
- R9: With `mrst` high, the control register, the mode register and the change flags are cleared. The output pins are then high and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mrst | input | 1 | Master reset, active high, asynchronous |
| sel_a | input | 1 | Select, active high |
| sel_b | input | 1 | Select, active high |
| sel_c_n | input | 1 | Select, active low |
| addr | input | 2 | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, 0 when not reading |
| cts_n | input | 1 | Clear-to-send pin, active low |
| dsr_n | input | 1 | Data-set-ready pin, active low |
| dcd_n | input | 1 | Carrier-detect pin, active low |
| ri_n | input | 1 | Ring-indicator pin, active low |
| dtr_n | output | 1 | Data-terminal-ready pin, active low |
| rts_n | output | 1 | Request-to-send pin, active low |
| out1_n | output | 1 | User output 1, active low |
| out2_n | output | 1 | User output 2, active low |
| irq | output | 1 | Modem-status interrupt request |
| tx_allow | output | 1 | Transmit permit for the transmitter |

## Verification
Two kinds of fault are targeted. A stuck or mis-cleared change flag shows on `irq` and in the status byte on the first read after the three-cycle synchronizer latency. A wrong loop-mode mapping shows in the status byte one cycle after the control write. Reads are timed to land on the exact edge where a pin change is detected, so a flag lost to the read-clear shows on the very next read. Select decoding is checked by an ignored write followed by a read-back, and by an ignored status read that must leave the flags in place.

// File: rtl/uart_modem_pkg.sv
package uart_modem_pkg;
    localparam int REG_AW = 2;
    localparam int DATA_W = 8;
    localparam logic [REG_AW-1:0] ADDR_CTRL = 2'd0;
    localparam logic [REG_AW-1:0] ADDR_STAT = 2'd1;
    localparam logic [REG_AW-1:0] ADDR_MODE = 2'd2;

    // bit order matches status byte positions (flags [3:0], levels [7:4])
    typedef struct packed {
        logic dcd;
        logic ri;
        logic dsr;
        logic cts;
    } modem_lines_t;

    typedef struct packed {
        logic loop_en;
        logic out2;
        logic out1;
        logic rts;
        logic dtr;
    } ctrl_t;

    typedef struct packed {
        logic auto_cts;
        logic int_en;
    } mode_t;
endpackage

// File: rtl/uart_modem_sync.sv
module uart_modem_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] INIT = '1
) (
    input  logic             clk,
    input  logic             mrst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] pipe_d [STAGES];
    logic [WIDTH-1:0] pipe_q [STAGES];

    always_comb begin
        pipe_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or posedge mrst) begin
        if (mrst) begin
            for (int i = 0; i < STAGES; i++) pipe_q[i] <= INIT;
        end else begin
            for (int i = 0; i < STAGES; i++) pipe_q[i] <= pipe_d[i];
        end
    end

    assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/uart_modem_regs.sv
module uart_modem_regs
    import uart_modem_pkg::*;
(
    input  logic              clk,
    input  logic              mrst,
    input  logic              hit,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] stat_byte,
    output ctrl_t             ctrl,
    output mode_t             mode,
    output logic [DATA_W-1:0] rd_data,
    output logic              stat_read
);
    typedef struct packed {
        ctrl_t ctrl;
        mode_t mode;
    } regs_t;

    regs_t state_d, state_q;
    logic  unused_wbits;

    assign unused_wbits = ^wr_data[DATA_W-1:5];

    always_comb begin
        state_d = state_q;
        if (hit && wr_en) begin
            unique case (addr)
                ADDR_CTRL: state_d.ctrl = ctrl_t'(wr_data[4:0]);
                ADDR_MODE: state_d.mode = mode_t'(wr_data[1:0]);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or posedge mrst) begin
        if (mrst) state_q <= '0;
        else      state_q <= state_d;
    end

    always_comb begin
        rd_data = '0;
        if (hit && rd_en) begin
            unique case (addr)
                ADDR_CTRL: rd_data = {3'b000, state_q.ctrl};
                ADDR_STAT: rd_data = stat_byte;
                ADDR_MODE: rd_data = {6'b000000, state_q.mode};
                default:   rd_data = '0;
            endcase
        end
    end

    assign stat_read = hit && rd_en && (addr == ADDR_STAT);
    assign ctrl      = state_q.ctrl;
    assign mode      = state_q.mode;

    assert_unselected_hold_R1: assert property (@(posedge clk) disable iff (mrst)
        !(hit && wr_en) |=> $stable(state_q))
        else $error("register changed without a selected write");
endmodule

// File: rtl/uart_modem_status.sv
module uart_modem_status
    import uart_modem_pkg::*;
(
    input  logic         clk,
    input  logic         mrst,
    input  modem_lines_t ext_lines,
    input  modem_lines_t loop_lines,
    input  logic         loop_en,
    input  logic         clear,
    input  mode_t        mode,
    output logic [7:0]   stat_byte,
    output logic         irq,
    output logic         tx_allow
);
    typedef struct packed {
        modem_lines_t lines;
        logic [3:0]   flags;
    } stat_t;

    stat_t        state_d, state_q;
    modem_lines_t sample;
    logic [3:0]   change;
    logic [3:0]   irq_mask;

    always_comb begin
        sample = loop_en ? loop_lines : ext_lines;
        change = 4'b0000;
        change[0] = sample.cts ^ state_q.lines.cts;
        change[1] = sample.dsr ^ state_q.lines.dsr;
        change[2] = state_q.lines.ri & ~sample.ri;
        change[3] = sample.dcd ^ state_q.lines.dcd;

        state_d.lines = sample;
        state_d.flags = (clear ? 4'b0000 : state_q.flags) | change;
    end

    always_ff @(posedge clk or posedge mrst) begin
        if (mrst) state_q <= '0;
        else      state_q <= state_d;
    end

    always_comb begin
        irq_mask = 4'b1110;
        irq_mask[0] = ~mode.auto_cts;
    end

    assign stat_byte = {state_q.lines, state_q.flags};
    assign irq       = mode.int_en && |(state_q.flags & irq_mask);
    assign tx_allow  = mode.auto_cts ? state_q.lines.cts : 1'b1;

    assert_flags_sticky_R5: assert property (@(posedge clk) disable iff (mrst)
        !clear |=> ((state_q.flags & $past(state_q.flags)) == $past(state_q.flags)))
        else $error("change flag dropped without a read");

    assert_read_clears_R6: assert property (@(posedge clk) disable iff (mrst)
        clear |=> ((state_q.flags & ~$past(change)) == 4'b0000))
        else $error("flag survived a status read");

    assert_irq_needs_enable_R7: assert property (@(posedge clk) disable iff (mrst)
        !mode.int_en |-> !irq)
        else $error("irq raised while disabled");

    assert_txallow_free_R8: assert property (@(posedge clk) disable iff (mrst)
        !mode.auto_cts |-> tx_allow)
        else $error("transmit blocked without auto-CTS");
endmodule

// File: rtl/uart_modem_ctl.sv
module uart_modem_ctl
    import uart_modem_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              mrst,
    input  logic              sel_a,
    input  logic              sel_b,
    input  logic              sel_c_n,
    input  logic [REG_AW-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              cts_n,
    input  logic              dsr_n,
    input  logic              dcd_n,
    input  logic              ri_n,
    output logic              dtr_n,
    output logic              rts_n,
    output logic              out1_n,
    output logic              out2_n,
    output logic              irq,
    output logic              tx_allow
);
    logic         hit;
    logic         stat_read;
    ctrl_t        ctrl;
    mode_t        mode;
    logic [7:0]   stat_byte;
    modem_lines_t pins_n, pins_sync_n, ext_lines, loop_lines;

    assign hit = sel_a & sel_b & ~sel_c_n;

    uart_modem_regs u_regs (
        .clk       (clk),
        .mrst      (mrst),
        .hit       (hit),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .addr      (addr),
        .wr_data   (wr_data),
        .stat_byte (stat_byte),
        .ctrl      (ctrl),
        .mode      (mode),
        .rd_data   (rd_data),
        .stat_read (stat_read)
    );

    assign pins_n = '{dcd: dcd_n, ri: ri_n, dsr: dsr_n, cts: cts_n};

    uart_modem_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .INIT(4'hF)) u_sync (
        .clk  (clk),
        .mrst (mrst),
        .din  (pins_n),
        .dout (pins_sync_n)
    );

    assign ext_lines  = ~pins_sync_n;
    assign loop_lines = '{dcd: ctrl.out2, ri: ctrl.out1, dsr: ctrl.dtr, cts: ctrl.rts};

    uart_modem_status u_status (
        .clk        (clk),
        .mrst       (mrst),
        .ext_lines  (ext_lines),
        .loop_lines (loop_lines),
        .loop_en    (ctrl.loop_en),
        .clear      (stat_read),
        .mode       (mode),
        .stat_byte  (stat_byte),
        .irq        (irq),
        .tx_allow   (tx_allow)
    );

    assign dtr_n  = ~(ctrl.dtr  & ~ctrl.loop_en);
    assign rts_n  = ~(ctrl.rts  & ~ctrl.loop_en);
    assign out1_n = ~(ctrl.out1 & ~ctrl.loop_en);
    assign out2_n = ~(ctrl.out2 & ~ctrl.loop_en);

    assert_loop_outputs_idle_R3: assert property (@(posedge clk) disable iff (mrst)
        ctrl.loop_en |-> ({dtr_n, rts_n, out1_n, out2_n} == 4'hF))
        else $error("output active during loop mode");

    assert_ignored_read_zero_R1: assert property (@(posedge clk) disable iff (mrst)
        !hit |-> (rd_data == 8'h00))
        else $error("read data without select");
endmodule

// File: tb/uart_modem_ctl_test.sv
module uart_modem_ctl_test;
    logic       clk = 1'b0;
    logic       mrst = 1'b1;
    logic       sel_a = 1'b0, sel_b = 1'b0, sel_c_n = 1'b1;
    logic [1:0] addr = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       cts_n = 1'b1, dsr_n = 1'b1, dcd_n = 1'b1, ri_n = 1'b1;
    logic       dtr_n, rts_n, out1_n, out2_n, irq, tx_allow;
    int         vectors = 0;
    int         fails = 0;
    bit         done = 1'b0;
    logic [7:0] v;

    always #2 clk = ~clk;

    uart_modem_ctl uut (
        .clk(clk), .mrst(mrst), .sel_a(sel_a), .sel_b(sel_b), .sel_c_n(sel_c_n),
        .addr(addr), .wr_en(wr_en), .rd_en(rd_en), .wr_data(wr_data), .rd_data(rd_data),
        .cts_n(cts_n), .dsr_n(dsr_n), .dcd_n(dcd_n), .ri_n(ri_n),
        .dtr_n(dtr_n), .rts_n(rts_n), .out1_n(out1_n), .out2_n(out2_n),
        .irq(irq), .tx_allow(tx_allow)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d, input bit good = 1'b1);
        {sel_a, sel_b, sel_c_n} = good ? 3'b110 : 3'b111;
        addr = a; wr_data = d; wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; {sel_a, sel_b, sel_c_n} = 3'b001;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d, input bit good = 1'b1);
        {sel_a, sel_b, sel_c_n} = good ? 3'b110 : 3'b010;
        addr = a; rd_en = 1'b1;
        #1 d = rd_data;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0; {sel_a, sel_b, sel_c_n} = 3'b001;
    endtask

    function automatic logic [7:0] pins_out();
        return {4'h0, dtr_n, rts_n, out1_n, out2_n};
    endfunction

    task automatic t_reset;
        check("R9 outputs idle after reset", pins_out(), 8'h0F);
        check("R9 irq low after reset", {7'b0, irq}, 8'h00);
        check("R8 tx_allow after reset", {7'b0, tx_allow}, 8'h01);
        rd(2'd0, v); check("R9 control cleared", v, 8'h00);
        rd(2'd1, v); check("R9 status cleared", v, 8'h00);
    endtask

    task automatic t_ctrl;
        wr(2'd0, 8'hEF);
        check("R2 all outputs active", pins_out(), 8'h00);
        rd(2'd0, v); check("R2 readback masks upper bits", v, 8'h0F);
        wr(2'd0, 8'h05);
        check("R2 dtr/out1 active only", pins_out(), 8'h05);
        rd(2'd0, v); check("R2 readback 05", v, 8'h05);
    endtask

    task automatic t_select;
        wr(2'd0, 8'h00, 1'b0);
        rd(2'd0, v); check("R1 unselected write ignored", v, 8'h05);
        check("R1 outputs unchanged", pins_out(), 8'h05);
        {sel_a, sel_b, sel_c_n} = 3'b100; addr = 2'd0; rd_en = 1'b1;
        #1 check("R1 unselected read returns zero", rd_data, 8'h00);
        @(negedge clk); rd_en = 1'b0; {sel_a, sel_b, sel_c_n} = 3'b001;
    endtask

    task automatic t_status;
        cts_n = 1'b0; settle(3);
        rd(2'd1, v); check("R4 R5 cts level and flag", v, 8'h11);
        rd(2'd1, v); check("R6 flag cleared by read", v, 8'h10);
        dsr_n = 1'b0; dcd_n = 1'b0; settle(3);
        rd(2'd1, v); check("R5 dsr and dcd flags", v, 8'hBA);
        rd(2'd1, v); check("R6 flags cleared", v, 8'hB0);
        ri_n = 1'b0; settle(3);
        rd(2'd1, v); check("R5 ri leading edge sets no flag", v, 8'hF0);
        ri_n = 1'b1; settle(3);
        rd(2'd1, v); check("R5 ri trailing edge flag", v, 8'hB4);
        rd(2'd1, v); check("R6 ri flag cleared", v, 8'hB0);
        cts_n = 1'b1; settle(3);
        rd(2'd1, v, 1'b0); check("R1 unselected status read zero", v, 8'h00);
        rd(2'd1, v); check("R1 unselected read kept flag", v, 8'hA1);
    endtask

    task automatic t_irq;
        wr(2'd2, 8'h01);
        check("R7 irq idle with no flag", {7'b0, irq}, 8'h00);
        dsr_n = 1'b1; settle(3);
        check("R7 irq on dsr change", {7'b0, irq}, 8'h01);
        rd(2'd1, v); check("R5 dsr falling flag", v, 8'h82);
        check("R7 irq drops after read", {7'b0, irq}, 8'h00);
        wr(2'd2, 8'h03);
        cts_n = 1'b0; settle(3);
        check("R7 auto-cts cts change no irq", {7'b0, irq}, 8'h00);
        check("R8 tx_allow follows cts on", {7'b0, tx_allow}, 8'h01);
        rd(2'd1, v); check("R5 cts flag under auto-cts", v, 8'h91);
        cts_n = 1'b1; settle(3);
        check("R8 tx_allow blocked", {7'b0, tx_allow}, 8'h00);
        check("R7 still no irq", {7'b0, irq}, 8'h00);
        rd(2'd1, v); check("R4 cts dropped", v, 8'h81);
        wr(2'd2, 8'h01);
        check("R8 tx_allow free without auto", {7'b0, tx_allow}, 8'h01);
        cts_n = 1'b0; settle(3);
        check("R7 cts change raises irq", {7'b0, irq}, 8'h01);
        rd(2'd1, v); check("R5 cts flag", v, 8'h91);
        wr(2'd2, 8'h00);
    endtask

    task automatic t_same_edge;
        dcd_n = 1'b1;
        @(posedge clk); @(negedge clk); @(posedge clk); @(negedge clk);
        rd(2'd1, v); check("R6 read before detection", v, 8'h90);
        rd(2'd1, v); check("R6 change on read edge kept", v, 8'h18);
    endtask

    task automatic t_loop;
        wr(2'd0, 8'h1F);
        check("R3 outputs idle in loop", pins_out(), 8'h0F);
        settle(1);
        rd(2'd1, v);
        rd(2'd1, v); check("R3 loop all lines", v, 8'hF0);
        wr(2'd0, 8'h1A);
        check("R3 outputs idle in loop 2", pins_out(), 8'h0F);
        settle(1);
        rd(2'd1, v); check("R3 loop mapping", v, 8'h96);
        wr(2'd0, 8'h00); settle(1);
        rd(2'd1, v);
        rd(2'd1, v); check("R4 external lines after loop", v, 8'h10);
    endtask

    task automatic t_mreset;
        wr(2'd0, 8'h0F); wr(2'd2, 8'h01);
        dsr_n = 1'b0; settle(3);
        check("R7 irq before reset", {7'b0, irq}, 8'h01);
        cts_n = 1'b1; dsr_n = 1'b1;
        mrst = 1'b1; #1;
        check("R9 outputs idle in reset", pins_out(), 8'h0F);
        check("R9 irq cleared", {7'b0, irq}, 8'h00);
        settle(2); mrst = 1'b0; settle(3);
        rd(2'd0, v); check("R9 control cleared", v, 8'h00);
        rd(2'd2, v); check("R9 mode cleared", v, 8'h00);
        rd(2'd1, v); check("R9 flags cleared", v, 8'h00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        settle(3);
        mrst = 1'b0;
        settle(3);
        t_reset;
        t_ctrl;
        t_select;
        t_status;
        t_irq;
        t_same_edge;
        t_loop;
        t_mreset;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule